// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block gathers a parameterised bank of external interrupt inputs (a multiple of eight, up to 256) and turns them into per-processor interrupt lines. Every input carries its own sense configuration: level or edge, active-high/rising or active-low/falling, and an optional both-edges mode. Each input is passed through a synchroniser. In level mode its pending bit tracks the synchronised input. In edge mode a latch holds the pending bit until software acknowledges it.

Software uses a plain word-addressed write/read port. Enabling and disabling an interrupt never needs a read-modify-write: the index is written to a set-enable or clear-enable register. A single software-trigger register either raises an edge latch (flag bit set) or acknowledges it (flag bit clear). Each input is routed through its own control word, which holds a routing-enable flag, an output pin number and a one-hot mask of target virtual processors. For every virtual processor the block drives a vector of pending, enabled and routed interrupts, plus one line per pin.

Top module: `shint_ctrl`

## Requirements
- R1: After reset every interrupt is disabled, active-high, level-sensed and unrouted. The per-interrupt control word at word address 0x400+i reads 0, the enable and pending words read 0, and both outputs are 0.
- R2: The word at address 0x000 returns GROUPS-1 in bits [7:0]. The interrupt count is (that field + 1) * 8.
- R3: A write of index i in bits [7:0] to address 0x001 enables interrupt i, and a write to 0x002 disables it. No other interrupt's enable changes. Enable bits read back at 0x200+w, where bit b is interrupt 32w+b.
- R4: In level mode (control bit 1 = 0), the pending bit (read at 0x100+w, bit b for interrupt 32w+b) equals the synchronised input XOR control bit 0. Control bit 0 = 1 means active-low.
- R5: In edge mode (control bit 1 = 1, bit 2 = 0), a rising edge latches pending when bit 0 = 0, and a falling edge latches it when bit 0 = 1. The latch holds after the input returns.
- R6: With control bit 2 = 1 in edge mode, both edges latch pending and bit 0 is ignored.
- R7: A write to address 0x003 with index in bits [7:0] sets the edge latch when bit 31 = 1 and clears it when bit 31 = 0. In level mode this write has no effect on the pending bit.
- R8: When a hardware edge and a clearing write to 0x003 hit the same latch in the same cycle, the latch ends up set.
- R9: vp_pend[v*NINT+i] is 1 when interrupt i is pending, enabled and has bit 16+v of its control word set. vp_irq[v*NUM_PINS+p] is 1 when some such interrupt also has control bit 15 (route enable) set and pin field bits [14:8] equal to p.
- R10: Writes to 0x001, 0x002 or 0x003 with an index of NINT or more, and writes to a control word above the last interrupt, change nothing. An out-of-range control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NINT | Asynchronous interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| vp_pend | output | NUM_VP*NINT | Per-processor pending-and-enabled vectors |
| vp_irq | output | NUM_VP*NUM_PINS | Per-processor, per-pin interrupt lines |

## Verification
A hardware edge arriving at an edge latch can coincide with a software acknowledge of that same latch. The bench first sets the latch by software. It then times a rising input so that the detected edge lands on the clock edge that also takes the clearing write. Afterwards the pending word must still show the bit set. A second, lone acknowledge must then clear it, which shows that the clear path itself works.

// File: rtl/shint_pkg.sv
package shint_pkg;
   typedef enum logic [3:0] {
      RGN_GLOBAL = 4'h0,
      RGN_PEND   = 4'h1,
      RGN_MASK   = 4'h2,
      RGN_CTL    = 4'h4
   } region_e;

   localparam logic [7:0] OFS_CFG   = 8'h00;
   localparam logic [7:0] OFS_MSET  = 8'h01;
   localparam logic [7:0] OFS_MCLR  = 8'h02;
   localparam logic [7:0] OFS_WEDGE = 8'h03;

   localparam int CTL_POL_BIT   = 0;
   localparam int CTL_EDGE_BIT  = 1;
   localparam int CTL_DUAL_BIT  = 2;
   localparam int CTL_PIN_LSB   = 8;
   localparam int CTL_PIN_MAXW  = 7;
   localparam int CTL_MAPEN_BIT = 15;
   localparam int CTL_VP_LSB    = 16;
   localparam int CTL_VP_MAXW   = 16;
   localparam int WEDGE_SET_BIT = 31;
endpackage

// File: rtl/shint_sense.sv
module shint_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_raw,
   input  logic pol_low,
   input  logic edge_mode,
   input  logic dual_edge,
   input  logic sw_set,
   input  logic sw_clr,
   output logic pend
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic prev_q, latch_q;
   logic now_lvl, rise, fall, hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign now_lvl = sync_q[SYNC_STAGES-1];
   assign rise    = now_lvl & ~prev_q;
   assign fall    = ~now_lvl & prev_q;
   assign hit     = dual_edge ? (rise | fall) : (pol_low ? fall : rise);

   // set beats clear so that an edge landing on an acknowledge is kept
   always_ff @(posedge clk) begin
      if (!rst_n)              latch_q <= 1'b0;
      else if (!edge_mode)     latch_q <= 1'b0;
      else if (hit || sw_set)  latch_q <= 1'b1;
      else if (sw_clr)         latch_q <= 1'b0;
   end

   assign pend = edge_mode ? latch_q : (now_lvl ^ pol_low);
endmodule

// File: rtl/shint_route.sv
module shint_route #(
   parameter int NINT     = 32,
   parameter int NUM_VP   = 2,
   parameter int NUM_PINS = 4,
   parameter int PIN_W    = 2
) (
   input  logic [NINT-1:0]              live,
   input  logic [NINT-1:0]              map_en,
   input  logic [NINT-1:0][PIN_W-1:0]   pin,
   input  logic [NINT-1:0][NUM_VP-1:0]  vp,
   output logic [NUM_VP*NINT-1:0]       vp_vec,
   output logic [NUM_VP*NUM_PINS-1:0]   lines
);
   for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
      for (genvar i = 0; i < NINT; i++) begin : g_src
         assign vp_vec[v*NINT+i] = live[i] & vp[i][v];
      end
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic any;
         always_comb begin
            any = 1'b0;
            for (int i = 0; i < NINT; i++)
               any = any | (live[i] & vp[i][v] & map_en[i] & (pin[i] == PIN_W'(p)));
         end
         assign lines[v*NUM_PINS+p] = any;
      end
   end
endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
   import shint_pkg::*;
#(
   parameter int GROUPS      = 4,
   parameter int NUM_VP      = 2,
   parameter int NUM_PINS    = 4,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [GROUPS*8-1:0]                    irq_in,
   input  logic                                   reg_we,
   input  logic [ADDR_W-1:0]                      reg_addr,
   input  logic [31:0]                            reg_wdata,
   output logic [31:0]                            reg_rdata,
   output logic [NUM_VP*GROUPS*8-1:0]             vp_pend,
   output logic [NUM_VP*NUM_PINS-1:0]             vp_irq
);
   localparam int NINT  = GROUPS * 8;
   localparam int IDX_W = (NINT > 1) ? $clog2(NINT) : 1;
   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
   localparam int WORDS = (NINT + 31) / 32;

   if (GROUPS < 1 || GROUPS > 32) begin : g_bad_groups
      $error("GROUPS must lie in 1..32");
   end
   if (NUM_VP < 1 || NUM_VP > CTL_VP_MAXW) begin : g_bad_vp
      $error("NUM_VP must lie in 1..16");
   end
   if (NUM_PINS < 2 || PIN_W > CTL_PIN_MAXW) begin : g_bad_pins
      $error("NUM_PINS must lie in 2..128");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // ---------------- address decode ----------------
   logic [3:0] region;
   logic       hi_ok;
   assign region = reg_addr[11:8];
   if (ADDR_W > 12) begin : g_hi
      assign hi_ok = (reg_addr[ADDR_W-1:12] == '0);
   end else begin : g_nohi
      assign hi_ok = 1'b1;
   end

   logic [IDX_W-1:0] w_idx, c_idx;
   logic             w_idx_ok, c_idx_ok;
   logic             wr_glob, wr_set, wr_clr, wr_wedge, wr_ctl;
   assign w_idx    = reg_wdata[IDX_W-1:0];
   assign w_idx_ok = (int'(reg_wdata[7:0]) < NINT);
   assign c_idx    = reg_addr[IDX_W-1:0];
   assign c_idx_ok = (int'(reg_addr[7:0]) < NINT);
   assign wr_glob  = reg_we && hi_ok && (region == RGN_GLOBAL);
   assign wr_set   = wr_glob && (reg_addr[7:0] == OFS_MSET)  && w_idx_ok;
   assign wr_clr   = wr_glob && (reg_addr[7:0] == OFS_MCLR)  && w_idx_ok;
   assign wr_wedge = wr_glob && (reg_addr[7:0] == OFS_WEDGE) && w_idx_ok;
   assign wr_ctl   = reg_we && hi_ok && (region == RGN_CTL) && c_idx_ok;

   // ---------------- per-interrupt state ----------------
   logic [NINT-1:0]             mask_q, pol_q, edge_q, dual_q, map_q, pend_w;
   logic [NINT-1:0][PIN_W-1:0]  pin_q;
   logic [NINT-1:0][NUM_VP-1:0] vp_q;

   for (genvar i = 0; i < NINT; i++) begin : g_int
      logic hit_w, hit_c;
      assign hit_w = (w_idx == IDX_W'(i));
      assign hit_c = (c_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n)                mask_q[i] <= 1'b0;
         else if (wr_set && hit_w)  mask_q[i] <= 1'b1;
         else if (wr_clr && hit_w)  mask_q[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pol_q[i]  <= 1'b0;
            edge_q[i] <= 1'b0;
            dual_q[i] <= 1'b0;
            map_q[i]  <= 1'b0;
            pin_q[i]  <= '0;
            vp_q[i]   <= '0;
         end else if (wr_ctl && hit_c) begin
            pol_q[i]  <= reg_wdata[CTL_POL_BIT];
            edge_q[i] <= reg_wdata[CTL_EDGE_BIT];
            dual_q[i] <= reg_wdata[CTL_DUAL_BIT];
            map_q[i]  <= reg_wdata[CTL_MAPEN_BIT];
            pin_q[i]  <= reg_wdata[CTL_PIN_LSB +: PIN_W];
            vp_q[i]   <= reg_wdata[CTL_VP_LSB +: NUM_VP];
         end
      end

      shint_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
         .clk       (clk),
         .rst_n     (rst_n),
         .irq_raw   (irq_in[i]),
         .pol_low   (pol_q[i]),
         .edge_mode (edge_q[i]),
         .dual_edge (dual_q[i]),
         .sw_set    (wr_wedge && hit_w &&  reg_wdata[WEDGE_SET_BIT]),
         .sw_clr    (wr_wedge && hit_w && !reg_wdata[WEDGE_SET_BIT]),
         .pend      (pend_w[i])
      );
   end

   // ---------------- routing ----------------
   logic [NUM_VP*NINT-1:0]     vec_c;
   logic [NUM_VP*NUM_PINS-1:0] line_c;

   shint_route #(
      .NINT(NINT), .NUM_VP(NUM_VP), .NUM_PINS(NUM_PINS), .PIN_W(PIN_W)
   ) u_route (
      .live   (pend_w & mask_q),
      .map_en (map_q),
      .pin    (pin_q),
      .vp     (vp_q),
      .vp_vec (vec_c),
      .lines  (line_c)
   );

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vp_pend <= '0;
            vp_irq  <= '0;
         end else begin
            vp_pend <= vec_c;
            vp_irq  <= line_c;
         end
      end
   end else begin : g_ocomb
      assign vp_pend = vec_c;
      assign vp_irq  = line_c;
   end

   // ---------------- read mux ----------------
   logic [WORDS*32-1:0] pend_pad, mask_pad;
   always_comb begin
      pend_pad = '0;
      mask_pad = '0;
      pend_pad[NINT-1:0] = pend_w;
      mask_pad[NINT-1:0] = mask_q;
   end

   always_comb begin
      reg_rdata = '0;
      if (hi_ok) begin
         unique case (region)
            RGN_GLOBAL: if (reg_addr[7:0] == OFS_CFG) reg_rdata[7:0] = 8'(GROUPS - 1);
            RGN_PEND:
               for (int w = 0; w < WORDS; w++)
                  if (reg_addr[7:0] == 8'(w)) reg_rdata = pend_pad[w*32 +: 32];
            RGN_MASK:
               for (int w = 0; w < WORDS; w++)
                  if (reg_addr[7:0] == 8'(w)) reg_rdata = mask_pad[w*32 +: 32];
            RGN_CTL:
               if (c_idx_ok) begin
                  reg_rdata[CTL_POL_BIT]              = pol_q[c_idx];
                  reg_rdata[CTL_EDGE_BIT]             = edge_q[c_idx];
                  reg_rdata[CTL_DUAL_BIT]             = dual_q[c_idx];
                  reg_rdata[CTL_MAPEN_BIT]            = map_q[c_idx];
                  reg_rdata[CTL_PIN_LSB +: PIN_W]     = pin_q[c_idx];
                  reg_rdata[CTL_VP_LSB +: NUM_VP]     = vp_q[c_idx];
               end
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/shint_ctrl_chk.sv
module shint_ctrl_chk #(
   parameter int NINT     = 32,
   parameter int IDX_W    = 5,
   parameter int ADDR_W   = 12,
   parameter int NUM_VP   = 2,
   parameter int NUM_PINS = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reg_we,
   input logic [ADDR_W-1:0]          reg_addr,
   input logic [31:0]                reg_wdata,
   input logic [NINT-1:0]            mask_q,
   input logic [NINT-1:0]            edge_q,
   input logic [NINT-1:0]            pend_w,
   input logic [NUM_VP*NUM_PINS-1:0] vp_irq
);
   logic             in_rng, set_go, clr_go, wset_go;
   logic [IDX_W-1:0] widx;
   assign widx    = reg_wdata[IDX_W-1:0];
   assign in_rng  = (int'(reg_wdata[7:0]) < NINT);
   assign set_go  = reg_we && (reg_addr == ADDR_W'(1)) && in_rng;
   assign clr_go  = reg_we && (reg_addr == ADDR_W'(2)) && in_rng;
   assign wset_go = reg_we && (reg_addr == ADDR_W'(3)) && in_rng && reg_wdata[31];

   // R3
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_go |=> mask_q[$past(widx)]);

   // R3
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_go |=> !mask_q[$past(widx)]);

   // R7
   wedge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wset_go && edge_q[widx]) |=> pend_w[$past(widx)]);

   // R9
   line_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vp_irq != '0) |-> ((|mask_q) || (|$past(mask_q))));
endmodule

bind shint_ctrl shint_ctrl_chk #(
   .NINT(NINT), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .NUM_VP(NUM_VP), .NUM_PINS(NUM_PINS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .mask_q    (mask_q),
   .edge_q    (edge_q),
   .pend_w    (pend_w),
   .vp_irq    (vp_irq)
);

// File: tb/shint_ctrl_tb.sv
module shint_ctrl_tb;
   localparam int GROUPS = 4, NUM_VP = 2, NUM_PINS = 4, ADDR_W = 12;
   localparam int NINT = GROUPS * 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                       rst_n;
   logic [NINT-1:0]            irq_in;
   logic                       reg_we;
   logic [ADDR_W-1:0]          reg_addr;
   logic [31:0]                reg_wdata, reg_rdata;
   logic [NUM_VP*NINT-1:0]     vp_pend;
   logic [NUM_VP*NUM_PINS-1:0] vp_irq;

   shint_ctrl #(.GROUPS(GROUPS), .NUM_VP(NUM_VP), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W))
   u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .vp_pend(vp_pend), .vp_irq(vp_irq)
   );

   typedef struct packed {
      logic [NUM_VP*NINT-1:0]     pend;
      logic [NUM_VP*NUM_PINS-1:0] lines;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   exp_t  cur;
   string cur_tag;
   int    n_cmp = 0, n_bad = 0;

   // monitor: pops expected output items and compares after each edge
   initial forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
         cur     = exp_q.pop_front();
         cur_tag = tag_q.pop_front();
         n_cmp++;
         if ({vp_pend, vp_irq} !== {cur.pend, cur.lines}) begin
            n_bad++;
            $display("FAIL %s: actual pend=%h lines=%h expected pend=%h lines=%h",
                     cur_tag, vp_pend, vp_irq, cur.pend, cur.lines);
         end
      end
   end

   task automatic expect_out(input string tag, input logic [NUM_VP*NINT-1:0] p,
                             input logic [NUM_VP*NUM_PINS-1:0] l);
      exp_t e;
      e.pend  = p;
      e.lines = l;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      n_cmp++;
      if (reg_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, reg_rdata, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [63:0] b64(input int k);
      return 64'd1 << k;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R2 configuration
      rd("R2 cfg", 12'h000, 32'd3);
      rd("R1 mask word", 12'h200, 32'h0);
      rd("R1 pend word", 12'h100, 32'h0);
      rd("R1 ctl default", 12'h405, 32'h0);
      expect_out("R1 outputs idle", '0, '0);

      // R3 enable set/clear by index, R10 out-of-range indices
      wr(12'h001, 32'd3);
      wr(12'h001, 32'd7);
      rd("R3 set two", 12'h200, 32'h88);
      wr(12'h002, 32'd3);
      rd("R3 clear one", 12'h200, 32'h80);
      wr(12'h001, 32'd40);
      wr(12'h002, 32'd200);
      rd("R10 index ignored", 12'h200, 32'h80);
      wr(12'h428, 32'hFFFF_FFFF);
      rd("R10 ctl out of range", 12'h428, 32'h0);

      // R4 level sense with routing (int 7 -> vp0, pin 2)
      wr(12'h407, 32'h0001_8200);
      rd("R9 ctl readback", 12'h407, 32'h0001_8200);
      irq_in[7] = 1'b1; settle(5);
      rd("R4 level high pend", 12'h100, 32'h80);
      expect_out("R9 level routed", b64(7), 8'h04);
      irq_in[7] = 1'b0; settle(5);
      rd("R4 level follows", 12'h100, 32'h0);
      expect_out("R4 level drop", '0, '0);
      wr(12'h407, 32'h0001_8201); settle(2);
      rd("R4 active low pend", 12'h100, 32'h80);
      expect_out("R4 active low out", b64(7), 8'h04);
      wr(12'h002, 32'd7); settle(2);
      rd("R3 disabled still pending", 12'h100, 32'h80);
      expect_out("R3 disabled silent", '0, '0);
      wr(12'h407, 32'h0001_8200);

      // R5 single edge (int 10 -> vp1, pin 1)
      wr(12'h40A, 32'h0002_8102);
      wr(12'h001, 32'd10);
      irq_in[10] = 1'b1; settle(5);
      irq_in[10] = 1'b0; settle(5);
      rd("R5 rising latched", 12'h100, 32'h400);
      expect_out("R9 edge routed vp1", b64(42), 8'h20);
      wr(12'h003, 32'h0000_000A); settle(2);
      rd("R7 wedge ack", 12'h100, 32'h0);
      wr(12'h40A, 32'h0002_8103);
      irq_in[10] = 1'b1; settle(5);
      rd("R5 falling ignores rise", 12'h100, 32'h0);
      irq_in[10] = 1'b0; settle(5);
      rd("R5 falling latched", 12'h100, 32'h400);
      wr(12'h003, 32'h0000_000A); settle(2);

      // R6 dual edge, polarity ignored (int 12 -> both vps, pin 3)
      wr(12'h40C, 32'h0003_8307);
      wr(12'h001, 32'd12);
      irq_in[12] = 1'b1; settle(5);
      rd("R6 rise latched", 12'h100, 32'h1000);
      expect_out("R6 both vps", b64(12) | b64(44), 8'h88);
      wr(12'h003, 32'h0000_000C); settle(2);
      irq_in[12] = 1'b0; settle(5);
      rd("R6 fall latched", 12'h100, 32'h1000);
      wr(12'h003, 32'h0000_000C); settle(2);

      // R7 software trigger
      wr(12'h003, 32'h8000_000A); settle(2);
      rd("R7 wedge set", 12'h100, 32'h400);
      expect_out("R7 wedge drives line", b64(42), 8'h20);
      wr(12'h003, 32'h0000_000A);
      wr(12'h003, 32'h8000_0007); settle(2);
      rd("R7 level ignores wedge", 12'h100, 32'h0);

      // R8 edge and acknowledge in the same cycle
      wr(12'h40A, 32'h0002_8102);
      wr(12'h003, 32'h8000_000A);
      irq_in[10] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(12'h003, 32'h0000_000A);
      settle(2);
      rd("R8 set wins", 12'h100, 32'h400);
      wr(12'h003, 32'h0000_000A); settle(2);
      rd("R7 lone ack clears", 12'h100, 32'h0);
      irq_in[10] = 1'b0; settle(5);

      // R9 routing disabled keeps vector, drops line
      wr(12'h40A, 32'h0002_0102);
      wr(12'h003, 32'h8000_000A); settle(2);
      expect_out("R9 unrouted line", b64(42), 8'h00);

      settle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule